// File: doc/BRIEF.md
# I2C Master Read Controller

This block is a bus master that reads a run of bytes from one target on a two-wire bus with open-drain clock and data lines. A request supplies an address byte, which must have its read bit set, and a byte count. The block first checks both fields. It then confirms that the bus is idle and issues a START. It shifts the address out while it watches for arbitration loss, and it waits for the target's acknowledge. After that it turns around and clocks in the requested bytes. It acknowledges every byte except the last, sends a not-acknowledge after the last, and finishes with a STOP.

Each line is driven through an enable: a 1 pulls the line low and a 0 releases it. The block reads the real line levels back through a two-flop synchronizer. This readback serves three purposes: the idle check, clock stretching by the target, and data sampling. Every phase length is a parameter counted in clock cycles. `T_HOLD` covers the 4.7 us hold intervals, `T_HALF` covers half a low phase, and `STRETCH_MAX` bounds how long the block waits for the clock to rise. Each received byte appears on a data output with a one-cycle strobe. A one-cycle done pulse ends every request and carries a status code.

Top module: `i2c_rd_master`

## Requirements
- R1: A request whose address bit 0 is 0 is rejected without touching the bus. The done pulse and status 0x20 appear one cycle after the request is sampled.
- R2: A request whose count is 0 or greater than 255 is rejected without touching the bus. The done pulse and status 0x40 appear one cycle after the request is sampled. A count of 1 is accepted.
- R3: If the synchronized SCL and SDA are not both high during the idle check, the request ends with status 0x01 and the block drives neither line.
- R4: After START, the address goes out MSB first. Each address bit holds SCL low for 2*T_HALF cycles, with the data set at the midpoint of that low phase. SDA does not change while SCL is high.
- R5: When the block sends a 1 and reads SDA low while SCL is high, it has lost arbitration. It releases both lines, issues no STOP, and ends with status 0x08.
- R6: If SDA is seen high at any point in the high phase of the address acknowledge clock, the block pulls SCL low, issues a STOP and ends with status 0x02.
- R7: Each data bit holds SCL low for T_HOLD cycles with SDA released. SDA is sampled once SCL reads high. Bytes are assembled MSB first. Each byte is shown on rx_data_o with rx_valid_o high for exactly one cycle.
- R8: After each byte, the block drives SDA low as an acknowledge if more bytes remain. After the final byte it leaves SDA high as a not-acknowledge.
- R9: After the final not-acknowledge, the block issues exactly one STOP and ends with status 0x00.
- R10: If SCL is held low for STRETCH_MAX cycles while the block waits for it to rise, the block releases both lines and ends with status 0x10.
- R11: Out of reset, and whenever the block is idle, both line enables are 0. busy_o, done_o and status_o are 0 after reset.
- R12: A target holding SCL low for fewer than STRETCH_MAX cycles only delays the transfer. The received bytes and the status are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request pulse, sampled while idle |
| addr_i | input | 8 | Address byte; bit 0 must be 1 (read) |
| len_i | input | 9 | Number of bytes to read, 1 to 255 |
| scl_i | input | 1 | SCL line level read back |
| sda_i | input | 1 | SDA line level read back |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse when a request ends |
| status_o | output | 8 | Outcome code of the last request |

## Verification
Field rejections (R1, R2) complete at the clock edge that samples the request. The bench therefore checks done_o and status_o at the very next falling edge, not at some point inside a window. Line timing is measured by counting, on falling edges, the cycles during which scl_oe_o is held. An address bit must show exactly 2*T_HALF cycles and a data bit exactly T_HOLD cycles, because the enable register follows the state register with no extra delay. Bus outcomes arrive after the synchronizer delay and any clock stretching. For those the bench waits for the done pulse under a cycle bound and checks the status and the bytes it logged. The target model records the address, the acknowledge bits and the START/STOP conditions from the line levels.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_FREE, ST_START,
    ST_A_LO1, ST_A_LO2, ST_A_RISE, ST_A_HI,
    ST_K_LO1, ST_K_LO2, ST_K_RISE, ST_K_HI,
    ST_R_LO, ST_R_RISE, ST_R_HI,
    ST_M_LO1, ST_M_LO2, ST_M_RISE, ST_M_HI, ST_M_LO3,
    ST_P_LO1, ST_P_LO2, ST_P_RISE, ST_P_HI, ST_P_SDA
  } rd_state_e;

  localparam logic [7:0] RC_OK      = 8'h00;
  localparam logic [7:0] RC_BUSY    = 8'h01;
  localparam logic [7:0] RC_NOACK   = 8'h02;
  localparam logic [7:0] RC_ARB     = 8'h08;
  localparam logic [7:0] RC_TIMEOUT = 8'h10;
  localparam logic [7:0] RC_BADADDR = 8'h20;
  localparam logic [7:0] RC_BADLEN  = 8'h40;

  // States in which the master holds SCL low.
  function automatic logic scl_pulled(rd_state_e s);
    case (s)
      ST_A_LO1, ST_A_LO2, ST_K_LO1, ST_K_LO2, ST_R_LO,
      ST_M_LO1, ST_M_LO2, ST_M_LO3, ST_P_LO1, ST_P_LO2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] pipe_q;
      // Idle bus lines are high, so the chain resets to 1.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = pipe_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_rd_timer.sv
module i2c_rd_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (clr_i)            cnt_d = '0;
    else if (cnt_o != '1) cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_d;
  end

endmodule

// File: rtl/i2c_rd_shreg.sv
module i2c_rd_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (load_i)       q_d = load_val_i;
    else if (shift_i) q_d = {q_o[W-2:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

endmodule

// File: rtl/i2c_rd_master.sv
module i2c_rd_master
  import i2c_rd_pkg::*;
#(
  parameter int T_HOLD      = 75,
  parameter int T_HALF      = 38,
  parameter int STRETCH_MAX = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic [7:0] addr_i,
  input  logic [8:0] len_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] status_o
);

  localparam int BIG0  = (T_HOLD > T_HALF) ? T_HOLD : T_HALF;
  localparam int BIG   = (BIG0 > STRETCH_MAX) ? BIG0 : STRETCH_MAX;
  localparam int CW    = $clog2(BIG + 1);
  localparam logic [CW-1:0] HOLD_END = CW'(T_HOLD - 1);
  localparam logic [CW-1:0] HALF_END = CW'(T_HALF - 1);
  localparam logic [CW-1:0] TO_END   = CW'(STRETCH_MAX - 1);

  rd_state_e     state_q, state_d;
  logic          scl_oe_q, sda_oe_d, sda_oe_q;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    rem_q, rem_d;
  logic          nack_q, nack_d;
  logic [7:0]    res_q, res_d;
  logic [7:0]    status_q, status_d;
  logic          done_q, done_d;
  logic          valid_q, valid_d;
  logic          sh_load, sh_shift, sh_din;
  logic [7:0]    sh_q;
  logic [CW-1:0] tcnt;
  logic [1:0]    lines_s;
  logic          scl_s, sda_s;
  logic          hold_end, half_end, to_end, timeout;

  i2c_rd_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  // The phase timer restarts whenever the state changes.
  i2c_rd_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(state_d != state_q), .cnt_o(tcnt)
  );

  i2c_rd_shreg #(.W(8)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load_i(sh_load), .load_val_i(addr_i),
    .shift_i(sh_shift), .din_i(sh_din), .q_o(sh_q)
  );

  assign hold_end = (tcnt == HOLD_END);
  assign half_end = (tcnt == HALF_END);
  assign to_end   = (tcnt == TO_END);

  always_comb begin
    state_d  = state_q;
    sda_oe_d = sda_oe_q;
    bit_d    = bit_q;
    rem_d    = rem_q;
    nack_d   = nack_q;
    res_d    = res_q;
    status_d = status_q;
    done_d   = 1'b0;
    valid_d  = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_din   = 1'b0;
    timeout  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        if (!addr_i[0]) begin
          done_d = 1'b1; status_d = RC_BADADDR;
        end else if ((len_i == 9'd0) || len_i[8]) begin
          done_d = 1'b1; status_d = RC_BADLEN;
        end else begin
          state_d = ST_FREE; sh_load = 1'b1; rem_d = len_i[7:0]; bit_d = 3'd0;
        end
      end
      ST_FREE: begin
        if (!(scl_s && sda_s)) begin
          state_d = ST_IDLE; done_d = 1'b1; status_d = RC_BUSY;
        end else if (hold_end) begin
          state_d = ST_START; sda_oe_d = 1'b1;
        end
      end
      ST_START:  if (hold_end) state_d = ST_A_LO1;
      ST_A_LO1:  if (half_end) begin state_d = ST_A_LO2; sda_oe_d = ~sh_q[7]; end
      ST_A_LO2:  if (half_end) state_d = ST_A_RISE;
      ST_A_RISE: begin
        if (scl_s) begin
          if (!sda_oe_q && !sda_s) begin
            state_d = ST_IDLE; done_d = 1'b1; status_d = RC_ARB;
          end else begin
            state_d = ST_A_HI;
          end
        end else if (to_end) timeout = 1'b1;
      end
      ST_A_HI: if (hold_end) begin
        sh_shift = 1'b1;
        if (bit_q == 3'd7) begin bit_d = 3'd0; state_d = ST_K_LO1; end
        else begin bit_d = bit_q + 3'd1; state_d = ST_A_LO1; end
      end
      ST_K_LO1:  if (half_end) begin state_d = ST_K_LO2; sda_oe_d = 1'b0; end
      ST_K_LO2:  if (half_end) state_d = ST_K_RISE;
      ST_K_RISE: begin
        if (scl_s) begin state_d = ST_K_HI; nack_d = sda_s; end
        else if (to_end) timeout = 1'b1;
      end
      ST_K_HI: begin
        if (sda_s) nack_d = 1'b1;
        if (hold_end) begin
          if (nack_q || sda_s) begin state_d = ST_P_LO1; res_d = RC_NOACK; end
          else state_d = ST_R_LO;
        end
      end
      ST_R_LO:   if (hold_end) state_d = ST_R_RISE;
      ST_R_RISE: begin
        if (scl_s) begin
          sh_shift = 1'b1; sh_din = sda_s; state_d = ST_R_HI;
          if (bit_q == 3'd7) begin valid_d = 1'b1; rem_d = rem_q - 8'd1; end
        end else if (to_end) timeout = 1'b1;
      end
      ST_R_HI: if (hold_end) begin
        if (bit_q == 3'd7) begin bit_d = 3'd0; state_d = ST_M_LO1; end
        else begin bit_d = bit_q + 3'd1; state_d = ST_R_LO; end
      end
      ST_M_LO1:  if (half_end) begin state_d = ST_M_LO2; sda_oe_d = (rem_q != 8'd0); end
      ST_M_LO2:  if (half_end) state_d = ST_M_RISE;
      ST_M_RISE: begin
        if (scl_s) state_d = ST_M_HI;
        else if (to_end) timeout = 1'b1;
      end
      ST_M_HI:   if (hold_end) state_d = ST_M_LO3;
      ST_M_LO3:  if (half_end) begin
        if (rem_q == 8'd0) begin
          state_d = ST_P_LO2; sda_oe_d = 1'b1; res_d = RC_OK;
        end else begin
          state_d = ST_R_LO; sda_oe_d = 1'b0;
        end
      end
      ST_P_LO1:  if (half_end) begin state_d = ST_P_LO2; sda_oe_d = 1'b1; end
      ST_P_LO2:  if (hold_end) state_d = ST_P_RISE;
      ST_P_RISE: begin
        if (scl_s) state_d = ST_P_HI;
        else if (to_end) timeout = 1'b1;
      end
      ST_P_HI:   if (hold_end) begin state_d = ST_P_SDA; sda_oe_d = 1'b0; end
      ST_P_SDA: begin
        if (sda_s) begin state_d = ST_IDLE; done_d = 1'b1; status_d = res_q; end
        else if (to_end) timeout = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (timeout) begin
      state_d = ST_IDLE; done_d = 1'b1; status_d = RC_TIMEOUT;
    end
    if (state_d == ST_IDLE) sda_oe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      bit_q    <= 3'd0;
      rem_q    <= 8'd0;
      nack_q   <= 1'b0;
      res_q    <= 8'd0;
      status_q <= 8'd0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      scl_oe_q <= scl_pulled(state_d);
      sda_oe_q <= sda_oe_d;
      bit_q    <= bit_d;
      rem_q    <= rem_d;
      nack_q   <= nack_d;
      res_q    <= res_d;
      status_q <= status_d;
      done_q   <= done_d;
      valid_q  <= valid_d;
    end
  end

  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;
  assign rx_data_o  = sh_q;
  assign rx_valid_o = valid_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign status_o   = status_q;

  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  assert_reject_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i && !addr_i[0]) |=> (done_o && status_o == RC_BADADDR && !busy_o));

  assert_reject_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i && addr_i[0] && (len_i == 9'd0 || len_i[8]))
      |=> (done_o && status_o == RC_BADLEN && !busy_o));

  assert_addr_stable_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_A_HI) |-> $stable(sda_oe_o));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_sda_free_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_R_HI || state_q == ST_R_LO) |-> !sda_oe_o);

endmodule

// File: tb/i2c_rd_master_bench.sv
module i2c_rd_master_bench;

  localparam int TH = 6;
  localparam int TF = 4;
  localparam int SM = 40;

  logic clk, rst_n, req;
  logic [7:0] addr;
  logic [8:0] len;
  logic scl_oe, sda_oe, rx_valid, busy, done;
  logic [7:0] rx_data, status;
  logic ext_sda_low, slv_sda_low, slv_scl_low;
  wire scl_line = !(scl_oe | slv_scl_low);
  wire sda_line = !(sda_oe | slv_sda_low | ext_sda_low);

  int checks, errors;
  bit finished;

  // Target model configuration (written by tasks only).
  logic ack_addr;
  int arb_at, stretch_at, stretch_len;
  logic quiet;

  // Target model state (written by the monitor only).
  logic prev_scl, prev_sda, prev_valid, prev_oe, slv_quit;
  int rise_n, start_n, stop_n, act_n, rx_n, vbad, lo_run, stretch_left;
  logic [7:0] addr_seen;
  logic [7:0] rx_log [8];
  int lo_len [64];
  int ack_log [8];

  i2c_rd_master #(.T_HOLD(TH), .T_HALF(TF), .STRETCH_MAX(SM)) u_i2c_rd_master (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .len_i(len),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .busy_o(busy), .done_o(done),
    .status_o(status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int b);
    return 8'hC5 + 8'(b * 29);
  endfunction

  always @(negedge clk) begin
    if (!rst_n || quiet) begin
      slv_sda_low = 1'b0; slv_scl_low = 1'b0; stretch_left = 0; rise_n = 0;
      start_n = 0; stop_n = 0; act_n = 0; rx_n = 0; vbad = 0; lo_run = 0;
      addr_seen = 8'h00; slv_quit = 1'b0;
      for (int i = 0; i < 64; i++) lo_len[i] = 0;
      for (int i = 0; i < 8; i++) ack_log[i] = 2;
    end else begin
      if (scl_oe | sda_oe) act_n++;
      if (rx_valid) begin
        if (rx_n < 8) rx_log[rx_n] = rx_data;
        rx_n++;
        if (prev_valid) vbad++;
      end
      if (scl_oe) lo_run++;
      else begin
        if (prev_oe && rise_n < 64) lo_len[rise_n] = lo_run;
        lo_run = 0;
      end
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        start_n++; rise_n = 0; slv_quit = 1'b0;
      end
      if (prev_scl && scl_line && !prev_sda && sda_line) stop_n++;
      if (!prev_scl && scl_line) begin
        rise_n++;
        if (rise_n <= 8) addr_seen = {addr_seen[6:0], sda_line};
        if (rise_n >= 10 && ((rise_n - 10) % 9) == 8) begin
          if ((rise_n - 10) / 9 < 8) ack_log[(rise_n - 10) / 9] = sda_line ? 1 : 0;
          if (sda_line) slv_quit = 1'b1;
        end
      end
      if (prev_scl && !scl_line) begin
        slv_sda_low = 1'b0;
        if (arb_at != 0 && rise_n == arb_at) slv_sda_low = 1'b1;
        if (rise_n == 8) slv_sda_low = ack_addr;
        if (rise_n >= 9 && ack_addr && !slv_quit && ((rise_n - 9) % 9) < 8) begin
          logic [7:0] pv;
          pv = pat((rise_n - 9) / 9);
          slv_sda_low = !pv[7 - ((rise_n - 9) % 9)];
        end
        if (stretch_at != 0 && rise_n == stretch_at) stretch_left = stretch_len;
      end
      if (stretch_left > 0) begin slv_scl_low = 1'b1; stretch_left--; end
      else slv_scl_low = 1'b0;
    end
    prev_scl = scl_line; prev_sda = sda_line; prev_valid = rx_valid; prev_oe = scl_oe;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic prep();
    ack_addr = 1'b1; arb_at = 0; stretch_at = 0; stretch_len = 0; ext_sda_low = 1'b0;
    quiet = 1'b1;
    repeat (6) @(negedge clk);
    quiet = 1'b0;
    @(negedge clk);
  endtask

  task automatic request(logic [7:0] a, logic [8:0] n);
    @(negedge clk);
    addr = a; len = n; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(int limit, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R11 scl_oe after reset", int'(scl_oe), 0);
    chk("R11 sda_oe after reset", int'(sda_oe), 0);
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 status after reset", int'(status), 0);
  endtask

  task automatic t_bad_addr();
    prep();
    request(8'hA2, 9'd3);
    chk("R1 done next cycle", int'(done), 1);
    chk("R1 status", int'(status), 'h20);
    repeat (10) @(negedge clk);
    chk("R1 bus untouched", act_n, 0);
  endtask

  task automatic t_bad_len(logic [8:0] n);
    prep();
    request(8'hA3, n);
    chk("R2 done next cycle", int'(done), 1);
    chk("R2 status", int'(status), 'h40);
    repeat (10) @(negedge clk);
    chk("R2 bus untouched", act_n, 0);
  endtask

  task automatic t_busy();
    logic seen;
    prep();
    ext_sda_low = 1'b1;
    repeat (4) @(negedge clk);
    request(8'hA3, 9'd2);
    wait_done(50, seen);
    chk("R3 done seen", int'(seen), 1);
    chk("R3 status", int'(status), 'h01);
    chk("R3 no drive", act_n, 0);
    ext_sda_low = 1'b0;
  endtask

  task automatic t_read(logic [7:0] a, int n);
    logic seen;
    prep();
    request(a, 9'(n));
    wait_done(20000, seen);
    repeat (2) @(negedge clk);
    chk("R9 done seen", int'(seen), 1);
    chk("R9 status ok", int'(status), 'h00);
    chk("R9 one STOP", stop_n, 1);
    chk("R4 address on bus", int'(addr_seen), int'(a));
    chk("R4 address bit low time", lo_len[2], 2 * TF);
    chk("R7 data bit low time", lo_len[10], TH);
    chk("R7 byte count", rx_n, n);
    chk("R7 single-cycle strobe", vbad, 0);
    for (int b = 0; b < n && b < 8; b++) begin
      chk("R7 byte value", int'(rx_log[b]), int'(pat(b)));
      chk("R8 ack bit", ack_log[b], (b == n - 1) ? 1 : 0);
    end
  endtask

  task automatic t_noack();
    logic seen;
    prep();
    ack_addr = 1'b0;
    request(8'h91, 9'd2);
    wait_done(5000, seen);
    repeat (2) @(negedge clk);
    chk("R6 status", int'(status), 'h02);
    chk("R6 STOP issued", stop_n, 1);
    chk("R6 no bytes", rx_n, 0);
  endtask

  task automatic t_arb();
    logic seen;
    prep();
    arb_at = 2;
    request(8'hA3, 9'd2);
    wait_done(5000, seen);
    chk("R5 status", int'(status), 'h08);
    chk("R5 scl released", int'(scl_oe), 0);
    chk("R5 sda released", int'(sda_oe), 0);
    repeat (20) @(negedge clk);
    chk("R5 no STOP", stop_n, 0);
    chk("R5 no bytes", rx_n, 0);
  endtask

  task automatic t_stretch_ok();
    logic seen;
    prep();
    stretch_at = 12; stretch_len = 20;
    request(8'h5B, 9'd2);
    wait_done(20000, seen);
    chk("R12 status", int'(status), 'h00);
    chk("R12 byte count", rx_n, 2);
    chk("R12 byte 0", int'(rx_log[0]), int'(pat(0)));
    chk("R12 byte 1", int'(rx_log[1]), int'(pat(1)));
  endtask

  task automatic t_timeout();
    logic seen;
    prep();
    stretch_at = 12; stretch_len = 400;
    request(8'hA3, 9'd2);
    wait_done(5000, seen);
    chk("R10 status", int'(status), 'h10);
    chk("R10 scl released", int'(scl_oe), 0);
    chk("R10 sda released", int'(sda_oe), 0);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    req = 1'b0; addr = 8'h00; len = 9'd0;
    ack_addr = 1'b1; arb_at = 0; stretch_at = 0; stretch_len = 0;
    ext_sda_low = 1'b0; quiet = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_bad_addr();
    t_bad_len(9'd0);
    t_bad_len(9'd256);
    t_busy();
    t_read(8'hA3, 1);
    t_read(8'h6F, 3);
    t_noack();
    t_arb();
    t_stretch_ok();
    t_timeout();
    prep();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule